// File: doc/BRIEF.md
# Half-Duplex Transmit Retry and Deferral Controller

This block sequences each outgoing frame of a half-duplex Ethernet-style MAC. When a frame is ready it waits for the medium to go quiet, then strobes a transmit start. At the end of every transmit attempt it looks at the error flags that attempt reported. From those flags it either lets the frame complete, asks for a retransmission, or drops the frame. A separate edge detector watches the carrier-loss flag and can ask the serial-to-Ethernet queue to flush.

Four bits of a byte-wide control register change this policy. One bit lets frames start without waiting for carrier sense. One stops retries after a heartbeat failure. One stops retries after any of the seven other transmit errors. One stops the queue flush on carrier loss. In full-duplex mode, carrier sense and collisions are not used. A counter caps the number of attempts per frame. The data path, CRC, backoff timing, PHY and queue storage all sit outside this block.

Top module: `tx_retry_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write with `cfg_we` high updates it at the next clock edge. `cfg_rdata` returns bits 3:0 as written and bits 7:4 as 0. Bit meanings: 0 = suppress retry on the seven general errors, 1 = suppress retry on heartbeat failure, 2 = bypass deferral, 3 = inhibit flush.
- R2: In half-duplex mode with bit 2 clear, a ready frame waits while `crs` is high. `tx_start` pulses for one cycle, one cycle after the edge that samples `crs` low. From idle that is two cycles after `frame_ready` is first sampled.
- R3: With bit 2 set, `tx_start` follows the same timing regardless of `crs`.
- R4: An `attempt_done` with no active error flag returns the controller to idle. It raises neither `retry_req` nor `frame_drop`.
- R5: If a general error (jabber, carrier loss, excessive deferral, late collision, excessive collisions, underrun, collision) is reported and bit 0 is clear, `retry_req` pulses in the cycle after `attempt_done` is sampled. The defer check then repeats, so `tx_start` follows one cycle later when the medium is free.
- R6: If a general error is reported and bit 0 is set, `frame_drop` pulses for one cycle instead of `retry_req`, and the controller returns to idle.
- R7: A heartbeat failure retries when bit 1 is clear and drops when bit 1 is set; bit 0 has no effect on it. When errors from both classes are reported, a suppressing bit for any reported class makes the outcome a drop.
- R8: A frame gets at most 16 attempts. If the 16th attempt fails in a retriable way, `frame_drop` and `retry_exhausted` pulse together and no retry is requested.
- R9: Each rising edge of `err_lcar` produces a one-cycle `queue_flush` in the following cycle when bit 3 is clear, and none when bit 3 is set. A held-high `err_lcar` does not repeat the pulse.
- R10: With `full_duplex` high, `crs` is ignored for deferral, and collision and late collision are not treated as errors.
- R11: At most one of `tx_start`, `retry_req` and `frame_drop` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents, upper nibble zero |
| full_duplex | input | 1 | Full-duplex operating mode |
| crs | input | 1 | Carrier sense |
| frame_ready | input | 1 | A frame is waiting to be sent |
| attempt_done | input | 1 | End of a transmit attempt; error flags valid |
| err_jabber | input | 1 | Jabber timeout on this attempt |
| err_lcar | input | 1 | Loss of carrier (also flush source) |
| err_exdefer | input | 1 | Excessive deferral |
| err_latecol | input | 1 | Late collision |
| err_excol | input | 1 | Excessive collisions |
| err_underrun | input | 1 | Transmit underrun |
| err_col | input | 1 | Collision |
| err_hbeat | input | 1 | Heartbeat failure |
| tx_start | output | 1 | Start transmit strobe |
| retry_req | output | 1 | Retransmit request strobe |
| frame_drop | output | 1 | Frame abandoned strobe |
| retry_exhausted | output | 1 | Drop caused by the attempt limit |
| queue_flush | output | 1 | Serial-to-Ethernet queue flush strobe |

## Verification
The bench targets the 16th failed attempt. A counter that is off by one would either request a 16th retry or drop one attempt too early. It also reports a heartbeat failure together with a general error while only one suppress bit is set. A design that let one class override the other would retry when it should drop. A full-duplex collision must end the frame cleanly; a design still honouring collisions there would request a retry. Carrier loss is held high for several cycles, and a level-triggered flush would pulse more than once. The start latency after retry and after success is measured, which shows whether the sequencer re-entered the defer check or idle.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_XMIT = 2'd2
    } seq_state_e;

    // Policy bits, ordered to match their register positions 3..0
    typedef struct packed {
        logic flush_inhibit;
        logic defer_bypass;
        logic hb_noretry;
        logic err_noretry;
    } ctl_bits_t;

    typedef struct packed {
        logic hbeat;
        logic col;
        logic underrun;
        logic excol;
        logic latecol;
        logic exdefer;
        logic lcar;
        logic jabber;
    } tx_errs_t;

endpackage

// File: rtl/tx_retry_cfg.sv
module tx_retry_cfg
    import tx_retry_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output ctl_bits_t        ctl
);
    localparam int USED_W = $bits(ctl_bits_t);

    typedef struct packed {
        ctl_bits_t ctl;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    unused_hi;

    assign unused_hi = ^wdata[CFG_W-1:USED_W];

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctl = ctl_bits_t'(wdata[USED_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl   = st_q.ctl;
    assign rdata = {{(CFG_W-USED_W){1'b0}}, st_q.ctl};

endmodule

// File: rtl/tx_retry_policy.sv
module tx_retry_policy
    import tx_retry_pkg::*;
(
    input  ctl_bits_t ctl,
    input  tx_errs_t  errs,
    input  logic      full_duplex,
    output logic      any_err,
    output logic      must_drop
);
    tx_errs_t eff;
    logic     general_err;

    always_comb begin
        eff = errs;
        if (full_duplex) begin
            eff.col     = 1'b0;
            eff.latecol = 1'b0;
        end
        general_err = eff.jabber | eff.lcar | eff.exdefer | eff.latecol |
                      eff.excol | eff.underrun | eff.col;
        any_err     = general_err | eff.hbeat;
        must_drop   = (general_err & ctl.err_noretry) |
                      (eff.hbeat & ctl.hb_noretry);
    end

endmodule

// File: rtl/tx_retry_seq.sv
module tx_retry_seq
    import tx_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl,
    input  logic      full_duplex,
    input  logic      crs,
    input  logic      frame_ready,
    input  logic      attempt_done,
    input  logic      any_err,
    input  logic      must_drop,
    output logic      tx_start,
    output logic      retry_req,
    output logic      frame_drop,
    output logic      retry_exhausted
);
    localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_ATTEMPTS);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] attempts;
        logic             start;
        logic             retry;
        logic             drop;
        logic             exhausted;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    medium_free;

    assign medium_free = ~crs | ctl.defer_bypass | full_duplex;

    always_comb begin
        st_d           = st_q;
        st_d.start     = 1'b0;
        st_d.retry     = 1'b0;
        st_d.drop      = 1'b0;
        st_d.exhausted = 1'b0;
        case (st_q.state)
            SEQ_IDLE: begin
                if (frame_ready) begin
                    st_d.state    = SEQ_WAIT;
                    st_d.attempts = '0;
                end
            end
            SEQ_WAIT: begin
                if (medium_free) begin
                    st_d.start    = 1'b1;
                    st_d.attempts = st_q.attempts + 1'b1;
                    st_d.state    = SEQ_XMIT;
                end
            end
            SEQ_XMIT: begin
                if (attempt_done) begin
                    if (!any_err) begin
                        st_d.state = SEQ_IDLE;
                    end else if (must_drop) begin
                        st_d.drop  = 1'b1;
                        st_d.state = SEQ_IDLE;
                    end else if (st_q.attempts >= CNT_LIMIT) begin
                        st_d.drop      = 1'b1;
                        st_d.exhausted = 1'b1;
                        st_d.state     = SEQ_IDLE;
                    end else begin
                        st_d.retry = 1'b1;
                        st_d.state = SEQ_WAIT;
                    end
                end
            end
            default: begin
                st_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: SEQ_IDLE, attempts: '0, start: 1'b0,
                      retry: 1'b0, drop: 1'b0, exhausted: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_start        = st_q.start;
    assign retry_req       = st_q.retry;
    assign frame_drop      = st_q.drop;
    assign retry_exhausted = st_q.exhausted;

endmodule

// File: rtl/tx_flush_det.sv
module tx_flush_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lcar,
    input  logic inhibit,
    output logic flush
);
    typedef struct packed {
        logic lcar_prev;
        logic pulse;
    } fl_st_t;

    fl_st_t st_d, st_q;

    always_comb begin
        st_d.lcar_prev = lcar;
        st_d.pulse     = lcar & ~st_q.lcar_prev & ~inhibit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush = st_q.pulse;

endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl
    import tx_retry_pkg::*;
#(
    parameter int CFG_W        = 8,
    parameter int MAX_ATTEMPTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             full_duplex,
    input  logic             crs,
    input  logic             frame_ready,
    input  logic             attempt_done,
    input  logic             err_jabber,
    input  logic             err_lcar,
    input  logic             err_exdefer,
    input  logic             err_latecol,
    input  logic             err_excol,
    input  logic             err_underrun,
    input  logic             err_col,
    input  logic             err_hbeat,
    output logic             tx_start,
    output logic             retry_req,
    output logic             frame_drop,
    output logic             retry_exhausted,
    output logic             queue_flush
);
    ctl_bits_t ctl;
    tx_errs_t  errs;
    logic      any_err;
    logic      must_drop;

    assign errs = '{hbeat: err_hbeat, col: err_col, underrun: err_underrun,
                    excol: err_excol, latecol: err_latecol,
                    exdefer: err_exdefer, lcar: err_lcar, jabber: err_jabber};

    tx_retry_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ctl   (ctl)
    );

    tx_retry_policy u_policy (
        .ctl         (ctl),
        .errs        (errs),
        .full_duplex (full_duplex),
        .any_err     (any_err),
        .must_drop   (must_drop)
    );

    tx_retry_seq #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl             (ctl),
        .full_duplex     (full_duplex),
        .crs             (crs),
        .frame_ready     (frame_ready),
        .attempt_done    (attempt_done),
        .any_err         (any_err),
        .must_drop       (must_drop),
        .tx_start        (tx_start),
        .retry_req       (retry_req),
        .frame_drop      (frame_drop),
        .retry_exhausted (retry_exhausted)
    );

    tx_flush_det u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .lcar    (err_lcar),
        .inhibit (ctl.flush_inhibit),
        .flush   (queue_flush)
    );

endmodule

// File: rtl/tx_retry_ctrl_chk.sv
module tx_retry_ctrl_chk #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             full_duplex,
    input logic             crs,
    input logic             attempt_done,
    input logic             err_lcar,
    input logic             tx_start,
    input logic             retry_req,
    input logic             frame_drop,
    input logic             retry_exhausted,
    input logic             queue_flush
);
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_start, retry_req, frame_drop}));

    assert_defer_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(!crs || cfg_rdata[2] || full_duplex));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    assert_outcome_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_req || frame_drop) |-> $past(attempt_done));

    assert_exhaust_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_exhausted |-> frame_drop);

    assert_flush_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        queue_flush |-> $past(err_lcar && !cfg_rdata[3]));

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        queue_flush |=> !queue_flush);

endmodule

bind tx_retry_ctrl tx_retry_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rdata       (cfg_rdata),
    .full_duplex     (full_duplex),
    .crs             (crs),
    .attempt_done    (attempt_done),
    .err_lcar        (err_lcar),
    .tx_start        (tx_start),
    .retry_req       (retry_req),
    .frame_drop      (frame_drop),
    .retry_exhausted (retry_exhausted),
    .queue_flush     (queue_flush)
);

// File: tb/tx_retry_ctrl_tb.sv
module tx_retry_ctrl_tb;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       full_duplex = 1'b0;
    logic       crs = 1'b0;
    logic       frame_ready = 1'b0;
    logic       attempt_done = 1'b0;
    logic [7:0] errv = '0; // {hbeat,col,underrun,excol,latecol,exdefer,lcar,jabber}
    logic       tx_start, retry_req, frame_drop, retry_exhausted, queue_flush;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    tx_retry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .full_duplex(full_duplex), .crs(crs),
        .frame_ready(frame_ready), .attempt_done(attempt_done),
        .err_jabber(errv[0]), .err_lcar(errv[1]), .err_exdefer(errv[2]),
        .err_latecol(errv[3]), .err_excol(errv[4]), .err_underrun(errv[5]),
        .err_col(errv[6]), .err_hbeat(errv[7]),
        .tx_start(tx_start), .retry_req(retry_req), .frame_drop(frame_drop),
        .retry_exhausted(retry_exhausted), .queue_flush(queue_flush)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Returns number of cycles until tx_start is seen (0 if never within limit)
    task automatic wait_start(input int limit, output int lat);
        lat = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (tx_start && lat == 0) lat = i;
            if (lat != 0) break;
        end
    endtask

    task automatic begin_frame(input string req, input int exp_lat);
        int lat;
        frame_ready = 1'b1;
        wait_start(6, lat);
        frame_ready = 1'b0;
        check(req, lat, exp_lat);
    endtask

    // Ends the current attempt; returns {exhausted, drop, retry}
    task automatic end_attempt(input logic [7:0] e, output logic [2:0] res);
        errv = e;
        attempt_done = 1'b1;
        @(negedge clk);
        attempt_done = 1'b0;
        errv = '0;
        res = {retry_exhausted, frame_drop, retry_req};
    endtask

    task automatic t_reset;
        check("R1 reset rdata", int'(cfg_rdata), 0);
        check("R11 reset strobes", int'({tx_start, retry_req, frame_drop, retry_exhausted, queue_flush}), 0);
    endtask

    task automatic t_cfg;
        write_cfg(8'hFF);
        check("R1 upper nibble zero", int'(cfg_rdata), 8'h0F);
        write_cfg(8'h05);
        check("R1 readback", int'(cfg_rdata), 8'h05);
        write_cfg(8'h00);
    endtask

    task automatic t_clean;
        logic [2:0] r;
        begin_frame("R2 start latency", 2);
        end_attempt(8'h00, r);
        check("R4 clean outcome", int'(r), 0);
        begin_frame("R4 back to idle", 2);
        end_attempt(8'h00, r);
    endtask

    task automatic t_defer;
        int seen = 0;
        logic [2:0] r;
        crs = 1'b1;
        frame_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (tx_start) seen++;
        end
        frame_ready = 1'b0;
        check("R2 held while crs", seen, 0);
        crs = 1'b0;
        @(negedge clk);
        check("R2 start after crs drop", int'(tx_start), 1);
        end_attempt(8'h00, r);
    endtask

    task automatic t_bypass;
        logic [2:0] r;
        write_cfg(8'h04);
        crs = 1'b1;
        begin_frame("R3 bypass ignores crs", 2);
        end_attempt(8'h00, r);
        crs = 1'b0;
        write_cfg(8'h00);
    endtask

    task automatic t_col_retry;
        logic [2:0] r;
        int lat;
        begin_frame("R5 start", 2);
        end_attempt(8'h40, r);
        check("R5 collision retries", int'(r), 3'b001);
        wait_start(4, lat);
        check("R5 retry re-enters defer", lat, 1);
        end_attempt(8'h00, r);
        check("R4 success after retry", int'(r), 0);
    endtask

    task automatic t_suppress_all;
        logic [2:0] r;
        write_cfg(8'h01);
        for (int b = 0; b < 7; b++) begin
            begin_frame("R6 start", 2);
            end_attempt(8'(1 << b), r);
            check($sformatf("R6 drop on error bit %0d", b), int'(r), 3'b010);
        end
        begin_frame("R7 hb not governed by bit0", 2);
        end_attempt(8'h80, r);
        check("R7 hb retries with bit0 set", int'(r), 3'b001);
        end_attempt(8'h00, r);
        end_attempt(8'h00, r);
        begin_frame("R7 mixed start", 2);
        end_attempt(8'hC0, r);
        check("R7 mixed classes drop", int'(r), 3'b010);
        write_cfg(8'h02);
        begin_frame("R7 start", 2);
        end_attempt(8'h80, r);
        check("R7 hb suppressed drops", int'(r), 3'b010);
        begin_frame("R7 start2", 2);
        end_attempt(8'h40, r);
        check("R5 general err retries with only bit1", int'(r), 3'b001);
        @(negedge clk);
        end_attempt(8'h00, r);
        write_cfg(8'h00);
    endtask

    task automatic t_limit;
        logic [2:0] r;
        int lat;
        int starts = 1;
        int retries = 0;
        int exh = 0;
        begin_frame("R8 first start", 2);
        for (int a = 1; a <= 16; a++) begin
            end_attempt(8'h40, r);
            if (r[0]) retries++;
            if (r[2] && r[1]) exh++;
            if (a < 16) begin
                wait_start(4, lat);
                if (lat != 0) starts++;
            end
        end
        check("R8 attempts", starts, 16);
        check("R8 retries", retries, 15);
        check("R8 exhausted drop", exh, 1);
        begin_frame("R8 idle after drop", 2);
        end_attempt(8'h00, r);
    endtask

    task automatic t_flush;
        int pulses = 0;
        errv[1] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (queue_flush) pulses++;
        end
        errv[1] = 1'b0;
        check("R9 single flush pulse", pulses, 1);
        write_cfg(8'h08);
        pulses = 0;
        errv[1] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (queue_flush) pulses++;
        end
        errv[1] = 1'b0;
        check("R9 flush inhibited", pulses, 0);
        write_cfg(8'h00);
    endtask

    task automatic t_full_duplex;
        logic [2:0] r;
        full_duplex = 1'b1;
        crs = 1'b1;
        begin_frame("R10 crs ignored", 2);
        end_attempt(8'h48, r);
        check("R10 collisions ignored", int'(r), 0);
        begin_frame("R10 idle after collision", 2);
        end_attempt(8'h20, r);
        check("R10 underrun still retries", int'(r), 3'b001);
        @(negedge clk);
        end_attempt(8'h00, r);
        crs = 1'b0;
        full_duplex = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_clean;
        t_defer;
        t_bypass;
        t_col_retry;
        t_suppress_all;
        t_limit;
        t_flush;
        t_full_duplex;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule